// File: doc/BRIEF.md
# Page Write Buffer with Commit Timer

This block sits between a two-wire serial protocol controller and a byte-wide synchronous storage array. The controller opens a write with a start strobe that carries a 17-bit start address. It then hands over data bytes one at a time and closes the write with a stop strobe. The block collects the bytes in a one-page buffer, 256 bytes wide. The in-page offset advances with each byte and wraps inside the page, while the page number is fixed by the start address. Nothing reaches the array until the stop arrives. At the stop, the block scans the buffer one slot per clock and writes only the slots that were filled. It then holds a busy flag for a programmable number of clocks that stands in for the write-cycle time.

The array holds 512 pages of 256 bytes. While busy is high, the controller must refuse new traffic, and the block ignores every strobe it is given. A write-protect input stops the block from modifying the array. A new start that arrives before a stop throws away the bytes collected so far.

Top module: `pgwr_commit`

## Requirements
- R1: Every array write in a commit uses, as address bits 16:8, the page given by bits 16:8 of the start address, and those bits stay constant for the whole commit.
- R2: The k-th byte after a start (k counting from 0) is stored at in-page offset (start offset + k) mod 256. Bit 7:0 of the array address is that offset.
- R3: When more than 256 bytes are sent, a later byte replaces the earlier byte at the same offset, and only the last value is written to the array.
- R4: Only offsets that received a byte are written. No other location in the page sees a write.
- R5: The array write enable is low whenever busy is low, so no byte reaches the array before the stop.
- R6: A stop accepted with write-protect low raises busy on the next cycle for exactly 256 + TWR_CYCLES cycles. In the cycle that is c cycles after the stop edge (c from 0 to 255), offset c is written if it holds a byte.
- R7: While busy is high, start, byte and stop strobes have no effect. They neither change the buffered data nor open a new write.
- R8: A stop accepted with write-protect high ends the write with no commit and no busy. While write-protect is high, the array write enable is low.
- R9: A start that arrives before a stop discards the bytes collected so far without writing them.
- R10: After reset, busy and the array write enable are low.
- R11: Byte and stop strobes that arrive with no open write (no start since the last stop or commit) are ignored.
- R12: Priority in a single cycle is start over byte over stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Opens a write and loads the start address |
| hdr_addr | input | 17 | Start address (page in 16:8, offset in 7:0) |
| byte_vld | input | 1 | A data byte is presented this cycle |
| byte_data | input | 8 | Data byte |
| stop_in | input | 1 | Closes the open write |
| wp_in | input | 1 | Write protect, high blocks array changes |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 17 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit or write-cycle wait in progress |

## Verification
The in-RTL assertions check the following on every cycle: the write enable stays low outside busy and under write-protect, the page bits stay frozen through a commit, the scan offset advances by one per cycle, the buffer is locked while busy, and the hold counter steps down by one. Only the bench scenarios can show the rest. These are wrap placement across the page end, the last value winning after an overrun, a discarded write after a restart, strobes being ignored during busy or with no open write, and the exact busy length. The bench shows them by comparing a behavioural model against the ports every clock and by reading back what reached the array.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_FILL = 2'd1,
    PW_SCAN = 2'd2,
    PW_HOLD = 2'd3
  } pw_state_t;
endpackage

// File: rtl/pgwr_store.sv
module pgwr_store #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  filled_q;

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_off] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      filled_q <= '0;
    else if (clr)    filled_q <= '0;
    else if (wr_en)  filled_q[wr_off] <= 1'b1;
  end

  assign rd_data  = slot_q[rd_off];
  assign rd_valid = filled_q[rd_off];

  // R7: the mask cannot move while the block is busy
  assert_locked_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(filled_q));
  // R12: a restart and a byte are never taken together
  assert_clr_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && wr_en));
endmodule

// File: rtl/pgwr_hold_timer.sv
module pgwr_hold_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= CW'(CYCLES - 1);
    else if (run && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R6: the wait window shrinks by exactly one per clock
  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int OFF_W      = 8,
  parameter int DATA_W     = 8,
  parameter int TWR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_in,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_in,
  input  logic              wp_in,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  function automatic logic [OFF_W-1:0] step_off(input logic [OFF_W-1:0] o);
    return o + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [PAGE_W-1:0] p,
                                                  input logic [OFF_W-1:0]  o);
    return {p, o};
  endfunction

  pw_state_t         state_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  ptr_q;
  logic [OFF_W-1:0]  idx_q;

  logic hdr_fire, byte_fire, stop_fire, scan_last, hold_done;
  logic slot_valid;
  logic [DATA_W-1:0] slot_data;

  assign busy      = (state_q == PW_SCAN) || (state_q == PW_HOLD);
  assign hdr_fire  = start_in && !busy;
  assign byte_fire = byte_vld && !start_in && (state_q == PW_FILL);
  assign stop_fire = stop_in && !start_in && !byte_vld && (state_q == PW_FILL);
  assign scan_last = (state_q == PW_SCAN) && (idx_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        PW_IDLE, PW_FILL: begin
          if (hdr_fire) begin
            state_q <= PW_FILL;
            page_q  <= hdr_addr[ADDR_W-1:OFF_W];
            ptr_q   <= hdr_addr[OFF_W-1:0];
          end else if (byte_fire) begin
            ptr_q <= step_off(ptr_q);
          end else if (stop_fire) begin
            state_q <= wp_in ? PW_IDLE : PW_SCAN;
            idx_q   <= '0;
          end
        end
        PW_SCAN: begin
          idx_q <= step_off(idx_q);
          if (scan_last) state_q <= PW_HOLD;
        end
        PW_HOLD: begin
          if (hold_done) state_q <= PW_IDLE;
        end
        default: state_q <= PW_IDLE;
      endcase
    end
  end

  pgwr_store #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock     (busy),
    .clr      (hdr_fire),
    .wr_en    (byte_fire),
    .wr_off   (ptr_q),
    .wr_data  (byte_data),
    .rd_off   (idx_q),
    .rd_data  (slot_data),
    .rd_valid (slot_valid)
  );

  pgwr_hold_timer #(.CYCLES(TWR_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (scan_last),
    .run     (state_q == PW_HOLD),
    .expired (hold_done)
  );

  assign mem_we    = (state_q == PW_SCAN) && slot_valid && !wp_in;
  assign mem_addr  = join_addr(page_q, idx_q);
  assign mem_wdata = slot_data;

  // R5: array untouched outside the busy window
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);
  // R8: protect input always wins over a pending write
  assert_wp_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_in |-> !mem_we);
  // R1: page bits frozen across a commit
  assert_page_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:OFF_W]));
  // R6: scan walks the offsets one per clock
  assert_scan_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PW_SCAN) && $past(state_q == PW_SCAN))
      |-> (mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1)));
  // R10: quiet outputs once reset is released
  assert_reset_quiet_R10: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !mem_we));
endmodule

// File: tb/sim_pgwr_commit.sv
module sim_pgwr_commit;
  localparam int CLK_PERIOD = 10;
  localparam int TWR        = 12;
  localparam int PAGE       = 256;
  localparam int TOT        = PAGE + TWR;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_in = 1'b0, byte_vld = 1'b0, stop_in = 1'b0, wp_in = 1'b0;
  logic [16:0] hdr_addr = '0;
  logic [7:0]  byte_data = '0;
  logic        mem_we, busy;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwr_commit #(.TWR_CYCLES(TWR)) u0 (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .hdr_addr(hdr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_in(stop_in), .wp_in(wp_in),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] dut_img [int];
  logic [7:0] exp_img [int];
  logic [7:0] pend [int];
  int busy_left = 0, pg = 0, ptr = 0;
  bit in_txn = 0;
  logic s_st, s_bv, s_sp, s_wp, ew;
  logic [16:0] s_addr;
  logic [7:0]  s_bd;
  int c;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int img(input int a);
    return dut_img.exists(a) ? int'(dut_img[a]) : -1;
  endfunction

  // behavioural model, advanced on every edge and compared just after it
  always begin
    @(posedge clk);
    s_st = start_in; s_addr = hdr_addr; s_bv = byte_vld; s_bd = byte_data;
    s_sp = stop_in;  s_wp = wp_in;
    if (!rst_n) begin
      busy_left = 0; in_txn = 0; pend.delete();
    end else if (busy_left > 0) begin
      busy_left--;
    end else if (s_st) begin
      in_txn = 1; pg = int'(s_addr[16:8]); ptr = int'(s_addr[7:0]); pend.delete();
    end else if (in_txn && s_bv) begin
      pend[ptr] = s_bd; ptr = (ptr + 1) % PAGE;
    end else if (in_txn && s_sp) begin
      in_txn = 0;
      if (!s_wp) busy_left = TOT;
    end
    #1;
    if (rst_n && !done) begin
      c  = TOT - busy_left;
      ew = (busy_left > 0) && (c < PAGE) && pend.exists(c) && !wp_in;
      chk(busy == (busy_left > 0), "R6", "busy", busy, busy_left > 0);
      chk(mem_we == ew, "R5/R8", "mem_we", mem_we, ew);
      if (ew && mem_we) begin
        chk(mem_addr == 17'(pg * PAGE + c), "R1", "mem_addr", mem_addr, pg * PAGE + c);
        chk(mem_wdata == pend[c], "R2", "mem_wdata", mem_wdata, pend[c]);
      end
      if (ew) exp_img[pg * PAGE + c] = pend[c];
      if (mem_we) dut_img[int'(mem_addr)] = mem_wdata;
    end
  end

  task automatic hdr(input logic [16:0] a);
    @(negedge clk); start_in = 1; hdr_addr = a;
    @(negedge clk); start_in = 0;
  endtask
  task automatic put(input logic [7:0] d);
    @(negedge clk); byte_vld = 1; byte_data = d;
    @(negedge clk); byte_vld = 0;
  endtask
  task automatic stp();
    @(negedge clk); stop_in = 1;
    @(negedge clk); stop_in = 0;
  endtask
  task automatic wait_free();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_we == 0, "R10", "reset outputs", {busy, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && mem_we == 0, "R10", "after release", {busy, mem_we}, 0);

    // R1 R4: single byte write
    hdr(17'h12345); put(8'hA5); stp(); wait_free();
    chk(img(17'h12345) == 8'hA5, "R1", "single byte", img(17'h12345), 8'hA5);
    chk(img(17'h12344) == -1, "R4", "left neighbour", img(17'h12344), -1);
    chk(img(17'h12346) == -1, "R4", "right neighbour", img(17'h12346), -1);

    // R2: wrap from the page end to its start
    hdr(17'h0ABFE);
    for (int i = 0; i < 5; i++) put(8'(8'h30 + i));
    stp(); wait_free();
    chk(img(17'h0ABFF) == 8'h31, "R2", "offset FF", img(17'h0ABFF), 8'h31);
    chk(img(17'h0AB00) == 8'h32, "R2", "wrap to 00", img(17'h0AB00), 8'h32);
    chk(img(17'h0AB02) == 8'h34, "R2", "offset 02", img(17'h0AB02), 8'h34);
    chk(img(17'h0AC00) == -1, "R2", "next page untouched", img(17'h0AC00), -1);

    // R3: 300 bytes overrun, last value wins
    hdr(17'h1F010);
    for (int n = 0; n < 300; n++) put(8'((n * 7 + 3) & 255));
    stp(); wait_free();
    chk(img(17'h1F010) == ((256 * 7 + 3) & 255), "R3", "offset 10", img(17'h1F010), (256 * 7 + 3) & 255);
    chk(img(17'h1F03B) == ((299 * 7 + 3) & 255), "R3", "offset 3B", img(17'h1F03B), (299 * 7 + 3) & 255);
    chk(img(17'h1F03C) == ((44 * 7 + 3) & 255), "R3", "offset 3C", img(17'h1F03C), (44 * 7 + 3) & 255);

    // R9 R12: restart discards, start beats byte in one cycle
    hdr(17'h1A020); put(8'h11); put(8'h12); put(8'h13);
    @(negedge clk); start_in = 1; hdr_addr = 17'h1A080; byte_vld = 1; byte_data = 8'hEE;
    @(negedge clk); start_in = 0; byte_vld = 0;
    put(8'h21); put(8'h22); stp(); wait_free();
    chk(img(17'h1A020) == -1, "R9", "discarded byte", img(17'h1A020), -1);
    chk(img(17'h1A080) == 8'h21, "R12", "start over byte", img(17'h1A080), 8'h21);

    // R8: protect at stop, then protect during a commit
    hdr(17'h1B000); put(8'h55); wp_in = 1; stp(); wp_in = 0;
    chk(busy == 0, "R8", "no busy under wp", busy, 0);
    repeat (3) @(negedge clk);
    chk(img(17'h1B000) == -1, "R8", "wp stop write", img(17'h1B000), -1);
    hdr(17'h0C000);
    for (int i = 0; i < 16; i++) put(8'(8'h80 + i));
    stp(); wp_in = 1; repeat (3) @(negedge clk); wp_in = 0;
    // R7: strobes while busy are ignored
    hdr(17'h07700); put(8'h99); stp();
    wait_free();
    chk(img(17'h0C002) == -1, "R8", "wp mid commit", img(17'h0C002), -1);
    chk(img(17'h0C008) == 8'h88, "R8", "after wp drop", img(17'h0C008), 8'h88);
    chk(img(17'h07700) == -1, "R7", "busy header ignored", img(17'h07700), -1);

    // R11: stray byte and stop with no open write
    put(8'h66); stp(); repeat (4) @(negedge clk);
    chk(busy == 0, "R11", "stray stop", busy, 0);

    chk(exp_img.size() == dut_img.size(), "R6", "write count", dut_img.size(), exp_img.size());
    foreach (exp_img[a]) chk(img(a) == int'(exp_img[a]), "R6", "image entry", img(a), exp_img[a]);
    summary();
  end
endmodule